// File: doc/BRIEF.md
# Colour Palette Lookup Table with Register Front End

This block holds a colour lookup table of 256 main entries and four overlay entries (the overlay entries colour a hardware cursor). A CPU programs it through a small register window. It first writes an 8-bit entry index. It then moves the red, green and blue components of that entry one bus access at a time through a single shared data register. The block tracks which component comes next. After the third component it advances the index by itself, so a whole palette loads as one index write followed by a stream of data accesses.

One data offset targets the main table and another redirects the same component stream into the overlay table. Reads walk through the main table with the same sequencing. A separate combinational lookup port turns a pixel value, or an overlay selector, into a 24-bit RGB value for the display pipeline.

Top module: `palette_dac`

## Requirements
- R1: A 32-bit write at offset 0 loads the entry index from data bits 31:24 and returns the component sequencer to red, whatever component was pending.
- R2: A 32-bit write at offset 4 stores data bits 31:24 into the pending component of main entry [index]; successive writes fill red, then green, then blue.
- R3: After the blue component has been accessed (write at offset 4 or 12, or a read), the index advances by one modulo 256 (255 wraps to 0) and the sequencer returns to red.
- R4: A 32-bit write at offset 12 stores into overlay entry [index bits 1:0], with the same red/green/blue order and auto-increment as R2 and R3, and leaves the main table unchanged.
- R5: A 32-bit read at any offset returns the pending component of main entry [index] in bits 31:24 with bits 23:0 zero, and advances the sequencer exactly as a component write does.
- R6: After reset every entry is black (0x000000) except main entry 255 and overlay entries 0 and 2, which are white (0xFFFFFF); the index is 0 and the sequencer is at red.
- R7: Writes at offsets other than 0, 4 and 12 change neither the index, the sequencer nor any entry; an access with `bus_word` low is ignored entirely, and a read with `bus_word` low returns 0.
- R8: `lk_rgb` is combinational: red in bits 23:16, green in 15:8 and blue in 7:0 of main entry [`lk_idx`], or of overlay entry [`lk_idx` bits 1:0] when `lk_ovl` is high; a component write becomes visible there right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full 32-bit access; other sizes are ignored |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read access |
| lk_ovl | input | 1 | 1 = look up an overlay entry |
| lk_idx | input | 8 | Pixel value, or overlay selector in bits 1:0 |
| lk_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
A sequencer that is one component out of step shows at the very next data access. The byte lands in the wrong colour field of the entry, and the lookup port reads it back one cycle later. A wrong index or a missed increment leaves the expected entry unchanged while a neighbouring entry takes the colour. The bench therefore checks whole entries through the lookup port after every three-component group and probes the neighbours. Ignored accesses are caught by following them with a complete group and checking that the group lands intact in the intended entry.

// File: rtl/palette_pkg.sv
package palette_pkg;

  localparam int CW = 8;

  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_t;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};
  localparam rgb_t RGB_WHITE = '{r: '1, g: '1, b: '1};

  // Raw two-bit state to component; the unused code 3 counts as red.
  function automatic comp_t norm_comp(input logic [1:0] raw);
    case (raw)
      2'd1:    return C_GRN;
      2'd2:    return C_BLU;
      default: return C_RED;
    endcase
  endfunction

  function automatic comp_t next_comp(input comp_t c);
    case (c)
      C_RED:   return C_GRN;
      C_GRN:   return C_BLU;
      default: return C_RED;
    endcase
  endfunction

  function automatic rgb_t put_comp(input rgb_t e, input comp_t c,
                                    input logic [CW-1:0] v);
    rgb_t o;
    o = e;
    case (c)
      C_RED:   o.r = v;
      C_GRN:   o.g = v;
      default: o.b = v;
    endcase
    return o;
  endfunction

  function automatic logic [CW-1:0] get_comp(input rgb_t e, input comp_t c);
    case (c)
      C_RED:   return e.r;
      C_GRN:   return e.g;
      default: return e.b;
    endcase
  endfunction

  // Reset colour: only the last main entry is white.
  function automatic rgb_t main_init(input int i, input int n);
    return (i == n - 1) ? RGB_WHITE : RGB_BLACK;
  endfunction

  // Reset colour: overlay entries 0 and 2 are white.
  function automatic rgb_t ovl_init(input int j);
    return (j == 0 || j == 2) ? RGB_WHITE : RGB_BLACK;
  endfunction

endpackage

// File: rtl/palette_seq.sv
module palette_seq
  import palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step_evt,
  input  logic             ign_evt,
  output logic [IDX_W-1:0] idx,
  output comp_t            comp
);

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       comp_q;
  logic             wrap_step;

  assign comp      = norm_comp(comp_q);
  assign idx       = idx_q;
  assign wrap_step = step_evt && (comp == C_BLU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      comp_q <= C_RED;
    end else if (load_evt) begin
      idx_q  <= load_val;
      comp_q <= C_RED;
    end else if (step_evt) begin
      comp_q <= next_comp(comp);
      if (wrap_step) idx_q <= idx_q + 1'b1;
    end
  end

  AST_LOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (idx_q == $past(load_val)) && (comp_q == C_RED)); // R1

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_evt && comp == C_RED) |=> (comp_q == C_GRN)); // R2

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_step && !load_evt) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (comp_q == C_RED)); // R3

  AST_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    ign_evt |=> $stable(idx_q) && $stable(comp_q)); // R7

endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int NUM_MAIN = 256,
  parameter int NUM_OVL  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_main,
  input  logic             wr_ovl,
  input  comp_t            wr_comp,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CW-1:0]    wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  input  comp_t            rd_comp,
  output logic [CW-1:0]    rd_val,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_ovl,
  output rgb_t             lk_rgb
);

  localparam int OVL_W = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1;

  rgb_t main_q [NUM_MAIN];
  rgb_t ovl_q  [NUM_OVL];

  for (genvar gi = 0; gi < NUM_MAIN; gi++) begin : g_main
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        main_q[gi] <= main_init(gi, NUM_MAIN);
      else if (wr_main && (wr_idx == IDX_W'(gi)))
        main_q[gi] <= put_comp(main_q[gi], wr_comp, wr_val);
    end
  end

  for (genvar gj = 0; gj < NUM_OVL; gj++) begin : g_ovl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ovl_q[gj] <= ovl_init(gj);
      else if (wr_ovl && (wr_idx[OVL_W-1:0] == OVL_W'(gj)))
        ovl_q[gj] <= put_comp(ovl_q[gj], wr_comp, wr_val);
    end
  end

  assign rd_val = get_comp(main_q[rd_idx], rd_comp);
  assign lk_rgb = lk_ovl ? ovl_q[lk_idx[OVL_W-1:0]] : main_q[lk_idx];

  AST_ONE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_main && wr_ovl)); // R4

endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 8,
  parameter int NUM_MAIN = 256,
  parameter int NUM_OVL  = 4,
  parameter int OFF_IDX  = 0,
  parameter int OFF_MAIN = 4,
  parameter int OFF_OVL  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lk_ovl,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [3*CW-1:0]   lk_rgb
);

  localparam int LOW_W = DATA_W - CW;

  logic             acc_ok, wr_acc, rd_acc;
  logic             hit_idx, hit_main, hit_ovl;
  logic             load_evt, wr_main, wr_ovl, step_evt, ign_evt;
  logic [CW-1:0]    wr_byte, rd_val;
  logic [IDX_W-1:0] cur_idx;
  comp_t            cur_comp;
  rgb_t             lk_ent;
  logic             unused_low;

  assign acc_ok   = bus_sel && bus_word;
  assign wr_acc   = acc_ok && bus_we;
  assign rd_acc   = acc_ok && !bus_we;
  assign hit_idx  = (bus_addr == ADDR_W'(OFF_IDX));
  assign hit_main = (bus_addr == ADDR_W'(OFF_MAIN));
  assign hit_ovl  = (bus_addr == ADDR_W'(OFF_OVL));

  assign load_evt = wr_acc && hit_idx;
  assign wr_main  = wr_acc && hit_main;
  assign wr_ovl   = wr_acc && hit_ovl;
  assign step_evt = wr_main || wr_ovl || rd_acc;
  assign ign_evt  = (wr_acc && !hit_idx && !hit_main && !hit_ovl)
                 || (bus_sel && !bus_word);

  assign wr_byte    = bus_wdata[DATA_W-1 -: CW];
  assign unused_low = ^bus_wdata[LOW_W-1:0];

  palette_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .load_val (wr_byte[IDX_W-1:0]),
    .step_evt (step_evt),
    .ign_evt  (ign_evt),
    .idx      (cur_idx),
    .comp     (cur_comp)
  );

  palette_store #(
    .IDX_W    (IDX_W),
    .NUM_MAIN (NUM_MAIN),
    .NUM_OVL  (NUM_OVL)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_main (wr_main),
    .wr_ovl  (wr_ovl),
    .wr_comp (cur_comp),
    .wr_idx  (cur_idx),
    .wr_val  (wr_byte),
    .rd_idx  (cur_idx),
    .rd_comp (cur_comp),
    .rd_val  (rd_val),
    .lk_idx  (lk_idx),
    .lk_ovl  (lk_ovl),
    .lk_rgb  (lk_ent)
  );

  assign bus_rdata = rd_acc ? {rd_val, {LOW_W{1'b0}}} : '0;
  assign lk_rgb    = lk_ent;

  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> (bus_rdata[LOW_W-1:0] == '0)); // R5

  AST_PARTIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_word) |-> (bus_rdata == '0)); // R7

endmodule

// File: tb/sim_palette_dac.sv
module sim_palette_dac;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_word = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_ovl = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  palette_dac u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_ovl(lk_ovl), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus access: driven after a falling edge, accepted at the next rising edge.
  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v,
                        input logic word = 1'b1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = word;
    bus_addr = a; bus_wdata = {v, 24'h5A5A5A};
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_word = 1'b1;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d,
                        input logic word = 1'b1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_word = word; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_word = 1'b1;
  endtask

  task automatic look(input logic ovl, input logic [7:0] i,
                      output logic [23:0] c);
    lk_ovl = ovl; lk_idx = i;
    #1 c = lk_rgb;
  endtask

  task automatic put_entry(input logic [3:0] off, input logic [23:0] c);
    bus_wr(off, c[23:16]);
    bus_wr(off, c[15:8]);
    bus_wr(off, c[7:0]);
  endtask

  task automatic t_reset();
    logic [23:0] c;
    logic [31:0] d;
    look(0, 8'd0, c);   check("R6", "main0", {8'h0, c}, 32'h0);
    look(0, 8'd128, c); check("R6", "main128", {8'h0, c}, 32'h0);
    look(0, 8'd254, c); check("R6", "main254", {8'h0, c}, 32'h0);
    look(0, 8'd255, c); check("R6", "main255", {8'h0, c}, 32'hFFFFFF);
    look(1, 8'd0, c);   check("R6", "ovl0", {8'h0, c}, 32'hFFFFFF);
    look(1, 8'd1, c);   check("R6", "ovl1", {8'h0, c}, 32'h0);
    look(1, 8'd2, c);   check("R6", "ovl2", {8'h0, c}, 32'hFFFFFF);
    look(1, 8'd3, c);   check("R6", "ovl3", {8'h0, c}, 32'h0);
    // Index 0 at reset: the first write group must land in entry 0.
    put_entry(4'd4, 24'h0A0B0C);
    look(0, 8'd0, c);   check("R6", "index 0 after reset", {8'h0, c}, 32'h0A0B0C);
    bus_rd(4'd0, d);    check("R6", "index 1 red after group", d, 32'h0);
  endtask

  task automatic t_write_main();
    logic [23:0] c;
    bus_wr(4'd0, 8'h10);
    bus_wr(4'd4, 8'h11);
    look(0, 8'h10, c);  check("R2", "red first", {8'h0, c}, 32'h110000);
    bus_wr(4'd4, 8'h22);
    // Blue write: old value during the access cycle, new right after the edge.
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h33000000;
    look(0, 8'h10, c);  check("R8", "before edge", {8'h0, c}, 32'h112200);
    @(posedge clk);
    #1 bus_sel = 1'b0;
    look(0, 8'h10, c);  check("R8", "after edge", {8'h0, c}, 32'h112233);
    put_entry(4'd4, 24'h445566);
    look(0, 8'h11, c);  check("R3", "auto-increment", {8'h0, c}, 32'h445566);
    look(0, 8'h12, c);  check("R3", "neighbour untouched", {8'h0, c}, 32'h0);
  endtask

  task automatic t_wrap();
    logic [23:0] c;
    bus_wr(4'd0, 8'hFF);
    put_entry(4'd4, 24'hAABBCC);
    look(0, 8'hFF, c);  check("R3", "entry 255", {8'h0, c}, 32'hAABBCC);
    put_entry(4'd4, 24'h010203);
    look(0, 8'h00, c);  check("R3", "wrap to 0", {8'h0, c}, 32'h010203);
  endtask

  task automatic t_read();
    logic [31:0] d;
    bus_wr(4'd0, 8'h10);
    bus_rd(4'd4, d);    check("R5", "read red", d, 32'h11000000);
    bus_rd(4'd8, d);    check("R5", "read green", d, 32'h22000000);
    bus_rd(4'd0, d);    check("R5", "read blue", d, 32'h33000000);
    bus_rd(4'd4, d);    check("R5", "read next entry red", d, 32'h44000000);
    put_entry(4'd4, 24'hFFFFFF);
    bus_rd(4'd4, d);    check("R5", "read mixed into write order", d, 32'h0);
  endtask

  task automatic t_ovl();
    logic [23:0] c;
    bus_wr(4'd0, 8'h06);
    put_entry(4'd12, 24'h0A0B0C);
    look(1, 8'd2, c);   check("R4", "overlay 2", {8'h0, c}, 32'h0A0B0C);
    look(0, 8'h06, c);  check("R4", "main 6 unchanged", {8'h0, c}, 32'h0);
    put_entry(4'd12, 24'h0D0E0F);
    look(1, 8'd3, c);   check("R4", "overlay 3 after increment", {8'h0, c}, 32'h0D0E0F);
    look(0, 8'h07, c);  check("R4", "main 7 unchanged", {8'h0, c}, 32'h0);
  endtask

  task automatic t_ignored();
    logic [23:0] c;
    logic [31:0] d;
    bus_wr(4'd0, 8'h20);
    bus_wr(4'd4, 8'h21);
    bus_wr(4'd8, 8'h99);          // unused offset
    bus_wr(4'd4, 8'h77, 1'b0);    // not a full word
    bus_wr(4'd0, 8'h40, 1'b0);    // index load, not a full word
    bus_rd(4'd4, d, 1'b0);
    check("R7", "narrow read data", d, 32'h0);
    look(0, 8'h20, c);  check("R7", "entry after ignored", {8'h0, c}, 32'h210000);
    bus_wr(4'd4, 8'h22);
    bus_wr(4'd4, 8'h23);
    look(0, 8'h20, c);  check("R7", "group intact", {8'h0, c}, 32'h212223);
    look(0, 8'h40, c);  check("R7", "entry 0x40 untouched", {8'h0, c}, 32'h0);
  endtask

  task automatic t_reload_mid();
    logic [23:0] c;
    bus_wr(4'd0, 8'h30);
    bus_wr(4'd4, 8'h01);
    bus_wr(4'd0, 8'h31);
    put_entry(4'd4, 24'h040506);
    look(0, 8'h31, c);  check("R1", "reload restarts at red", {8'h0, c}, 32'h040506);
    look(0, 8'h30, c);  check("R1", "partial entry kept", {8'h0, c}, 32'h010000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_main();
    t_wrap();
    t_read();
    t_ovl();
    t_ignored();
    t_reload_mid();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule